// File: doc/BRIEF.md
# Flash Command Mode State Machine

This block interprets the write commands that reach a parallel NOR-flash model after its write qualification stage. Each accepted write pulse carries an address and a data byte. The block tracks which read mode is active: normal array read, identification, or parameter query. It then chooses what a read returns. That is either the array word supplied from outside, or a value from a small identification or query lookup indexed by the read address.

A byte/word pin selects the addressing form. In byte mode, every command address is twice its word-mode value, and table reads use the byte address divided by two. A busy input from the embedded program/erase engine blocks entry to query mode. A forced-reset input returns the machine to array read from any state.

The read mode is visible on a two-bit output. The read data leaves through a register, one clock after the address is presented.

Top module: `flash_cmd_fsm`

## Requirements
- R1: While rst_n is low, rd_mode is 0 (array read) and rd_data is 0000h; after release the machine starts in array read.
- R2: With rd_mode = 0, rd_data at each rising edge takes the value array_data had just before that edge, in byte mode as well as word mode.
- R3: Three accepted writes enter identification mode (rd_mode = 1): AAh to 555h, then 55h to 2AAh, then 90h to 555h. In byte mode the addresses are AAAh, 554h, AAAh. The full write address must match.
- R4: Any write that is not the expected next step of that unlock sequence clears the progress and leaves the read mode unchanged. An unlock sequence can start again right after.
- R5: Data 98h written to address 55h (byte mode: AAh) in array read or identification mode enters query mode (rd_mode = 2). 98h to any other address has no effect.
- R6: While busy is high, the query command is ignored and the read mode stays as it was.
- R7: Data F0h at any address in query mode returns to the mode query was entered from: array read (0) or identification (1).
- R8: Data F0h at any address in identification mode returns to array read.
- R9: force_rst high at a rising edge returns the machine to array read. This holds from any mode and wins over a write accepted in the same cycle.
- R10: In query mode, word offsets 10h, 11h and 12h read as 0051h, 0052h and 0059h ("Q", "R", "Y"). All other offsets read 0000h. In byte mode the word offset is the byte address shifted right by one, odd byte addresses read 0000h, and the upper byte is 00h.
- R11: In identification mode, word offset 0 reads 0001h and offset 1 reads 22A5h. All other offsets read 0000h. Byte mode uses the same offset rule and returns only the low byte (00A5h at byte address 2).
- R12: In query mode, every write other than F0h is ignored, including the unlock writes and a repeated query command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle pulse for an accepted write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write command data |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| busy | input | 1 | Embedded program/erase engine is running |
| force_rst | input | 1 | Forced return to array read |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 16 | Word read from the array |
| rd_data | output | 16 | Registered read data |
| rd_mode | output | 2 | Read mode: 0 array, 1 identification, 2 query |

## Verification
Two pairs of functions can fall in the same cycle. The first is the forced reset together with an accepted write: the bench raises force_rst on the same edge as a query command, and requires array read on the next cycle. The second is the busy input together with a query command: the bench issues the command with busy high, and requires the mode to stay unchanged.

A behavioural model in the bench follows each clock. It judges both collisions, and also the read data, which must still reflect the mode that held before the edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_QUERY = 2'd2
  } rmode_e;

  typedef struct packed {
    logic rst_cmd;
    logic qry_cmd;
    logic unlk1;
    logic unlk2;
    logic asel;
  } cmd_hit_t;

  localparam logic [7:0]  DAT_RESET = 8'hF0;
  localparam logic [7:0]  DAT_QUERY = 8'h98;
  localparam logic [7:0]  DAT_UNLK1 = 8'hAA;
  localparam logic [7:0]  DAT_UNLK2 = 8'h55;
  localparam logic [7:0]  DAT_ASEL  = 8'h90;

  // word-form command addresses; byte form is twice these
  localparam logic [11:0] ADR_UNLK1 = 12'h555;
  localparam logic [11:0] ADR_UNLK2 = 12'h2AA;
  localparam logic [11:0] ADR_QUERY = 12'h055;

  localparam logic [15:0] ID_MANUF  = 16'h0001;
  localparam logic [15:0] ID_DEVICE = 16'h22A5;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              byte_mode,
  output cmd_hit_t          hit
);

  localparam int SH_W = ADDR_W + 1;

  // command address in the form selected by the mode pin
  function automatic logic [ADDR_W-1:0] form_addr(input logic [11:0] word_a,
                                                   input logic        bm);
    logic [SH_W-1:0] wide;
    wide = SH_W'(word_a);
    if (bm) wide = wide << 1;
    return wide[ADDR_W-1:0];
  endfunction

  logic a_unlk1, a_unlk2, a_query;

  always_comb begin
    a_unlk1 = (wr_addr == form_addr(ADR_UNLK1, byte_mode));
    a_unlk2 = (wr_addr == form_addr(ADR_UNLK2, byte_mode));
    a_query = (wr_addr == form_addr(ADR_QUERY, byte_mode));

    hit.rst_cmd = (wr_data == DAT_RESET);
    hit.qry_cmd = a_query && (wr_data == DAT_QUERY);
    hit.unlk1   = a_unlk1 && (wr_data == DAT_UNLK1);
    hit.unlk2   = a_unlk2 && (wr_data == DAT_UNLK2);
    hit.asel    = a_unlk1 && (wr_data == DAT_ASEL);
  end

endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import flash_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     force_rst,
  input  logic     wr_stb,
  input  logic     busy,
  input  cmd_hit_t hit,
  output rmode_e   mode
);

  localparam int STEP_W = 2;

  rmode_e             mode_q, mode_d;
  rmode_e             org_q, org_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic               upd;

  // next-state process
  always_comb begin
    mode_d = mode_q;
    org_d  = org_q;
    step_d = step_q;
    if (force_rst) begin
      mode_d = MODE_ARRAY;
      org_d  = MODE_ARRAY;
      step_d = '0;
    end else if (wr_stb) begin
      if (mode_q == MODE_QUERY) begin
        step_d = '0;
        if (hit.rst_cmd) begin
          mode_d = org_q;
          org_d  = MODE_ARRAY;
        end
      end else if (hit.rst_cmd) begin
        mode_d = MODE_ARRAY;
        step_d = '0;
      end else if (hit.qry_cmd && !busy) begin
        mode_d = MODE_QUERY;
        org_d  = mode_q;
        step_d = '0;
      end else begin
        unique case (step_q)
          2'd0:    step_d = hit.unlk1 ? 2'd1 : 2'd0;
          2'd1:    step_d = hit.unlk2 ? 2'd2 : 2'd0;
          2'd2: begin
            step_d = '0;
            if (hit.asel) mode_d = MODE_IDENT;
          end
          default: step_d = '0;
        endcase
      end
    end
  end

  assign upd = force_rst | wr_stb;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      org_q  <= MODE_ARRAY;
      step_q <= '0;
    end else if (upd) begin
      mode_q <= mode_d;
      org_q  <= org_d;
      step_q <= step_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/flash_info_rom.sv
module flash_info_rom
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int IDX_W  = 6
) (
  input  rmode_e            mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              byte_mode,
  output logic [15:0]       info
);

  localparam int          TAB_N   = 1 << IDX_W;
  localparam logic [15:0] QRY_Q   = 16'h0051;
  localparam logic [15:0] QRY_R   = 16'h0052;
  localparam logic [15:0] QRY_Y   = 16'h0059;
  localparam int          QRY_OFF = 16;

  logic [ADDR_W-1:0] woff;
  logic              in_tab;
  logic [IDX_W-1:0]  idx;
  logic [15:0]       qry_tab [TAB_N];
  logic [15:0]       id_tab  [TAB_N];
  logic [15:0]       raw;

  // table contents computed per entry
  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    localparam logic [15:0] QV = (g == QRY_OFF)     ? QRY_Q :
                                 (g == QRY_OFF + 1) ? QRY_R :
                                 (g == QRY_OFF + 2) ? QRY_Y : 16'h0000;
    localparam logic [15:0] IV = (g == 0) ? ID_MANUF  :
                                 (g == 1) ? ID_DEVICE : 16'h0000;
    assign qry_tab[g] = QV;
    assign id_tab[g]  = IV;
  end

  always_comb begin
    woff   = byte_mode ? (rd_addr >> 1) : rd_addr;
    in_tab = ((woff >> IDX_W) == '0) && !(byte_mode && rd_addr[0]);
    idx    = woff[IDX_W-1:0];
    if (!in_tab)                 raw = 16'h0000;
    else if (mode == MODE_QUERY) raw = qry_tab[idx];
    else                         raw = id_tab[idx];
    info = byte_mode ? {8'h00, raw[7:0]} : raw;
  end

endmodule

// File: rtl/flash_rd_reg.sv
module flash_rd_reg
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rmode_e            mode,
  input  logic [DATA_W-1:0] array_data,
  input  logic [DATA_W-1:0] info,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] sel_d;
  logic              rd_en;

  always_comb begin
    sel_d = (mode == MODE_ARRAY) ? array_data : info;
    rd_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel_d;
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              byte_mode,
  input  logic              busy,
  input  logic              force_rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_mode
);

  cmd_hit_t    hit;
  rmode_e      mode;
  logic [15:0] info;

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .byte_mode (byte_mode),
    .hit       (hit)
  );

  flash_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_rst (force_rst),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .hit       (hit),
    .mode      (mode)
  );

  flash_info_rom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rom (
    .mode      (mode),
    .rd_addr   (rd_addr),
    .byte_mode (byte_mode),
    .info      (info)
  );

  flash_rd_reg #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .array_data (array_data),
    .info       (DATA_W'(info)),
    .rd_data    (rd_data)
  );

  assign rd_mode = mode;

endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              force_rst,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        rd_mode
);

  logic f0_wr;
  assign f0_wr = wr_stb && (wr_data == 8'hF0) && !force_rst;

  // R1: only the three defined modes occur
  a_r1_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode != 2'd3);

  a_r2_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd0) |=> (rd_data == $past(array_data)));

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy && rd_mode != 2'd2) |=> (rd_mode != 2'd2));

  a_r7_query_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2 && f0_wr) |=> (rd_mode != 2'd2));

  a_r8_ident_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd1 && f0_wr) |=> (rd_mode == 2'd0));

  a_r9_force_array: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> (rd_mode == 2'd0));

  a_r12_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2 && !force_rst && !(wr_stb && wr_data == 8'hF0))
      |=> (rd_mode == 2'd2));

endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .wr_data    (wr_data),
  .busy       (busy),
  .force_rst  (force_rst),
  .array_data (array_data),
  .rd_data    (rd_data),
  .rd_mode    (rd_mode)
);

// File: tb/test_flash_cmd_fsm.sv
`timescale 1ns/1ps
module test_flash_cmd_fsm;

  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb, byte_mode, busy, force_rst;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data;
  logic [15:0]   array_data;
  logic [15:0]   rd_data;
  logic [1:0]    rd_mode;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_fsm i_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
    .force_rst(force_rst), .rd_addr(rd_addr), .array_data(array_data),
    .rd_data(rd_data), .rd_mode(rd_mode)
  );

  // changing array word
  always @(posedge clk) begin
    #1 array_data <= array_data + 16'h1357;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_mode, m_org, m_step;
  logic [15:0] m_rd;

  function automatic logic [15:0] m_table(input int md, input logic [AW-1:0] a,
                                          input logic bm, input logic [15:0] arr);
    int off;
    int v;
    if (md == 0) return arr;
    off = bm ? int'(a >> 1) : int'(a);
    if (bm && a[0]) return 16'h0000;
    v = 0;
    if (md == 2) begin
      if (off == 16) v = 'h51;
      else if (off == 17) v = 'h52;
      else if (off == 18) v = 'h59;
    end else begin
      if (off == 0) v = 'h0001;
      else if (off == 1) v = 'h22A5;
    end
    if (bm) v = v & 'hFF;
    return 16'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int ua, ub, qa, wa;
    if (!rst_n) begin
      m_mode = 0; m_org = 0; m_step = 0; m_rd = 16'h0;
    end else begin
      m_rd = m_table(m_mode, rd_addr, byte_mode, array_data);
      ua = byte_mode ? 'hAAA : 'h555;
      ub = byte_mode ? 'h554 : 'h2AA;
      qa = byte_mode ? 'hAA  : 'h55;
      wa = int'(wr_addr);
      if (force_rst) begin
        m_mode = 0; m_org = 0; m_step = 0;
      end else if (wr_stb) begin
        if (m_mode == 2) begin
          if (wr_data == 8'hF0) begin m_mode = m_org; m_org = 0; end
        end else if (wr_data == 8'hF0) begin
          m_mode = 0; m_step = 0;
        end else if (wr_data == 8'h98 && wa == qa && !busy) begin
          m_org = m_mode; m_mode = 2; m_step = 0;
        end else if (m_step == 0) begin
          m_step = (wr_data == 8'hAA && wa == ua) ? 1 : 0;
        end else if (m_step == 1) begin
          m_step = (wr_data == 8'h55 && wa == ub) ? 2 : 0;
        end else begin
          if (wr_data == 8'h90 && wa == ua) m_mode = 1;
          m_step = 0;
        end
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("model mode", {14'h0, rd_mode}, 16'(m_mode));
      chk("model data", rd_data, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_stb = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); #2;
    wr_stb = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v, output logic [15:0] arr);
    @(posedge clk); #2;
    rd_addr = AW'(a);
    @(negedge clk);
    arr = array_data;
    @(posedge clk); #2;
    v = rd_data;
  endtask

  task automatic unlock(input logic bm);
    wr(bm ? 'hAAA : 'h555, 8'hAA);
    wr(bm ? 'h554 : 'h2AA, 8'h55);
    wr(bm ? 'hAAA : 'h555, 8'h90);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v, arr;
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    byte_mode = 1'b0; busy = 1'b0; force_rst = 1'b0; rd_addr = '0;
    array_data = 16'h1234;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 mode in reset", {14'h0, rd_mode}, 16'd0);
    chk("R1 data in reset", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 mode after release", {14'h0, rd_mode}, 16'd0);

    // R2 array pass-through
    for (int i = 0; i < 4; i++) begin
      rd(i * 7 + 16, v, arr);
      chk("R2 array data", v, arr);
    end

    // R3 and R11 identification, word mode
    unlock(1'b0);
    chk("R3 ident entry word", {14'h0, rd_mode}, 16'd1);
    rd(0, v, arr); chk("R11 manuf id", v, 16'h0001);
    rd(1, v, arr); chk("R11 device id", v, 16'h22A5);
    rd(5, v, arr); chk("R11 empty offset", v, 16'h0000);

    // R8 reset from identification
    wr('h123, 8'hF0);
    chk("R8 ident exit", {14'h0, rd_mode}, 16'd0);

    // R4 aborted unlock, then a clean restart
    wr('h555, 8'hAA);
    wr('h2AB, 8'h55);
    wr('h555, 8'h90);
    chk("R4 abort keeps array", {14'h0, rd_mode}, 16'd0);
    unlock(1'b0);
    chk("R4 restart works", {14'h0, rd_mode}, 16'd1);
    wr('h0, 8'hF0);

    // R5 query entry from array, R10 table, R12 ignored writes, R7 exit
    wr('h56, 8'h98);
    chk("R5 wrong query address", {14'h0, rd_mode}, 16'd0);
    wr('h55, 8'h98);
    chk("R5 query entry", {14'h0, rd_mode}, 16'd2);
    rd('h10, v, arr); chk("R10 Q", v, 16'h0051);
    rd('h11, v, arr); chk("R10 R", v, 16'h0052);
    rd('h12, v, arr); chk("R10 Y", v, 16'h0059);
    rd('h13, v, arr); chk("R10 other", v, 16'h0000);
    unlock(1'b0);
    wr('h55, 8'h98);
    chk("R12 query holds", {14'h0, rd_mode}, 16'd2);
    wr('h7, 8'hF0);
    chk("R7 back to array", {14'h0, rd_mode}, 16'd0);

    // R7 query from identification returns there
    unlock(1'b0);
    wr('h55, 8'h98);
    chk("R5 query from ident", {14'h0, rd_mode}, 16'd2);
    wr('h55, 8'hF0);
    chk("R7 back to ident", {14'h0, rd_mode}, 16'd1);
    wr('h0, 8'hF0);

    // R6 busy collides with query command
    busy = 1'b1;
    wr('h55, 8'h98);
    chk("R6 busy ignores query", {14'h0, rd_mode}, 16'd0);
    busy = 1'b0;

    // byte mode: R3, R11, R10
    byte_mode = 1'b1;
    unlock(1'b1);
    chk("R3 ident entry byte", {14'h0, rd_mode}, 16'd1);
    rd(2, v, arr); chk("R11 byte device id", v, 16'h00A5);
    wr('h55, 8'h98);
    chk("R5 byte form rejects word address", {14'h0, rd_mode}, 16'd1);
    wr('hAA, 8'h98);
    chk("R5 byte query entry", {14'h0, rd_mode}, 16'd2);
    rd('h20, v, arr); chk("R10 byte Q", v, 16'h0051);
    rd('h24, v, arr); chk("R10 byte Y", v, 16'h0059);
    rd('h21, v, arr); chk("R10 byte odd", v, 16'h0000);

    // R9 forced reset wins over a same-cycle write
    @(posedge clk); #2;
    force_rst = 1'b1; wr_stb = 1'b1; wr_addr = AW'('hAA); wr_data = 8'h98;
    @(posedge clk); #2;
    force_rst = 1'b0; wr_stb = 1'b0;
    chk("R9 force from query", {14'h0, rd_mode}, 16'd0);
    rd(9, v, arr); chk("R2 byte array data", v, arr);
    byte_mode = 1'b0;
    unlock(1'b0);
    @(posedge clk); #2;
    force_rst = 1'b1; wr_stb = 1'b1; wr_addr = AW'('h55); wr_data = 8'h98;
    @(posedge clk); #2;
    force_rst = 1'b0; wr_stb = 1'b0;
    chk("R9 force from ident", {14'h0, rd_mode}, 16'd0);

    repeat (3) @(posedge clk);
    #2;
    summary();
    $finish;
  end

endmodule